// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running 64-bit count of nanoseconds for the precision time logic of a network port. Every clock cycle, while the block is enabled, it adds a programmable fixed-point increment with 32 fraction bits to an internal accumulator. The increment is a whole number of nanoseconds in its upper 32 bits and a binary fraction in its lower 32 bits. Software chooses the increment from the tick period of the clock: 0x1_9999_9999 for a 1.6 ns tick, twice that for 3.2 ns, twenty times that for 32 ns. Small changes to the increment trim the clock frequency, and an increment of zero stops the clock.

A 32-bit register bus reaches the time and the increment, each split into a low and a high word. A read of the low time word takes a snapshot of the whole 64-bit time, and the high word read after it returns the upper half of that snapshot. Writes stage the low word and act only when the high word is written, so a 64-bit value is never applied half-written.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, the time, the fraction, the increment, both staged low words, the snapshot and the enable bit are zero, and every register reads back as zero.
- R2: While the enable bit is clear, the time does not change except through a time load.
- R3: While enabled, each cycle adds the 64-bit increment (bits 63:32 whole nanoseconds, bits 31:0 fraction) to a 96-bit accumulator. The time registers show only its upper 64 bits, and fraction carries reach the nanosecond count.
- R4: A read of address 3 (time, low word) returns bits 31:0 of the current time and captures all 64 bits. A later read of address 4 (time, high word) returns bits 63:32 of that capture, whatever the time has become since.
- R5: A write to address 3 only stages a low word; the running time is not changed by it.
- R6: A write to address 4 loads the time with {write data, staged low word} and clears the fraction. In that cycle no increment is added, even when the block is enabled.
- R7: A write to address 1 only stages the low increment word. A write to address 2 makes {write data, staged low word} the active increment, which is used from the next cycle on.
- R8: With an active increment of zero the accumulator holds its value while enabled.
- R9: The time wraps from 0xFFFF_FFFF_FFFF_FFFF past zero without stopping.
- R10: The read data and rd_valid are registered: they appear in the cycle after rd_en, and rd_valid is high for exactly that cycle.
- R11: Address 0 bit 0 is the enable bit, and it reads back as written. Addresses 1 and 2 read back the low and high words of the active increment, not the staged word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0 control, 1 increment low, 2 increment high, 3 time low, 4 time high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High in the cycle that rdata holds the result of a read |

## Verification
Every read result is due one cycle after the edge that samples rd_en. The value it returns is the state just before that edge, so a snapshot and an increment read see nothing from the same edge's write or tick. The bench keeps a cycle-level model that updates on the same rising edge as the design and queues the expected word when a read is sampled. A monitor on the falling edge then pops the queue only when rd_valid is high and flags any rd_valid that the model did not predict. A load, an increment commit or an enable change thus shows up in the first read issued after it, and the checks depend on no fixed wait counts.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL    = 3'd0,
    ADR_INC_LO  = 3'd1,
    ADR_INC_HI  = 3'd2,
    ADR_TIME_LO = 3'd3,
    ADR_TIME_HI = 3'd4
  } reg_addr_e;

  localparam logic [63:0] BASE_INC_1P6NS = 64'h0000_0001_9999_9999;
endpackage

// File: rtl/ptp_tc_split_stage.sv
module ptp_tc_split_stage #(
  parameter int DW   = 32,
  parameter bit HOLD = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic            commit,
  output logic [2*DW-1:0] value
);
  logic [DW-1:0] stage_lo;

  always_ff @(posedge clk) begin
    if (!rst_n)     stage_lo <= '0;
    else if (wr_lo) stage_lo <= wdata;
  end

  assign commit = wr_hi;

  generate
    if (HOLD) begin : g_hold
      logic [2*DW-1:0] held;
      always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (wr_hi)  held <= {wdata, stage_lo};
      end
      assign value = held;
    end else begin : g_pass
      assign value = {wdata, stage_lo};
    end
  endgenerate
endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int INC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [INC_W-1:0]  inc,
  output logic [NS_W-1:0]   time_ns,
  output logic [FRAC_W-1:0] frac
);
  localparam int ACC_W = NS_W + FRAC_W;

  function automatic logic [ACC_W-1:0] acc_step(input logic [ACC_W-1:0] a,
                                                input logic [INC_W-1:0] d);
    return a + ACC_W'(d);
  endfunction

  logic [ACC_W-1:0] acc;
  logic             tick;

  assign tick = enable && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (load) acc <= {load_ns, {FRAC_W{1'b0}}};
    else if (tick) acc <= acc_step(acc, inc);
  end

  assign time_ns = acc[ACC_W-1:FRAC_W];
  assign frac    = acc[FRAC_W-1:0];
endmodule

// File: rtl/ptp_tc_snap.sv
module ptp_tc_snap #(
  parameter int NS_W = 64,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [NS_W-1:0] time_ns,
  output logic [DW-1:0]   snap_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)       snap_hi <= '0;
    else if (capture) snap_hi <= time_ns[NS_W-1:DW];
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int DW     = 32,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);
  import ptp_tc_pkg::*;
  localparam int INC_W = 2 * DW;

  logic              enable_q;
  logic              time_commit, inc_commit;
  logic [NS_W-1:0]   time_load_ns, time_ns;
  logic [INC_W-1:0]  inc_val;
  logic [FRAC_W-1:0] acc_frac;
  logic [DW-1:0]     snap_hi;
  logic              sel_ctrl, sel_ilo, sel_ihi, sel_tlo, sel_thi;

  assign sel_ctrl = addr == AW'(ADR_CTRL);
  assign sel_ilo  = addr == AW'(ADR_INC_LO);
  assign sel_ihi  = addr == AW'(ADR_INC_HI);
  assign sel_tlo  = addr == AW'(ADR_TIME_LO);
  assign sel_thi  = addr == AW'(ADR_TIME_HI);

  always_ff @(posedge clk) begin
    if (!rst_n)                  enable_q <= 1'b0;
    else if (wr_en && sel_ctrl)  enable_q <= wdata[0];
  end

  ptp_tc_split_stage #(.DW(DW), .HOLD(1'b0)) u_time_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr_en && sel_tlo), .wr_hi(wr_en && sel_thi),
    .wdata(wdata), .commit(time_commit), .value(time_load_ns)
  );

  ptp_tc_split_stage #(.DW(DW), .HOLD(1'b1)) u_inc_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr_en && sel_ilo), .wr_hi(wr_en && sel_ihi),
    .wdata(wdata), .commit(inc_commit), .value(inc_val)
  );

  ptp_tc_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .enable(enable_q),
    .load(time_commit), .load_ns(time_load_ns), .inc(inc_val),
    .time_ns(time_ns), .frac(acc_frac)
  );

  ptp_tc_snap #(.NS_W(NS_W), .DW(DW)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(rd_en && sel_tlo),
    .time_ns(time_ns), .snap_hi(snap_hi)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_ctrl: rd_mux = DW'(enable_q);
      sel_ilo:  rd_mux = inc_val[DW-1:0];
      sel_ihi:  rd_mux = inc_val[INC_W-1:DW];
      sel_tlo:  rd_mux = time_ns[DW-1:0];
      sel_thi:  rd_mux = snap_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ptp_tc_checker.sv
module ptp_tc_checker #(
  parameter int DW     = 32,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              enable_q,
  input logic              time_commit,
  input logic [NS_W-1:0]   time_load_ns,
  input logic [NS_W-1:0]   time_ns,
  input logic              inc_commit,
  input logic [2*DW-1:0]   inc_val,
  input logic [FRAC_W-1:0] acc_frac
);
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q && !time_commit) |=> ($stable(time_ns) && $stable(acc_frac))); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    time_commit |=> (time_ns == $past(time_load_ns) && acc_frac == '0)); // R6
  AST_INC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_commit |=> $stable(inc_val)); // R7
  AST_ZERO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_val == '0 && !time_commit) |=> ($stable(time_ns) && $stable(acc_frac))); // R8
  AST_RD_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R10
  AST_RD_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R10
endmodule

bind ptp_time_counter ptp_tc_checker #(.DW(DW), .NS_W(NS_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .enable_q(enable_q), .time_commit(time_commit), .time_load_ns(time_load_ns),
  .time_ns(time_ns), .inc_commit(inc_commit), .inc_val(inc_val), .acc_frac(acc_frac)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;

  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  // reference state, updated on the same edge as the design
  logic [95:0] m_acc;
  logic [63:0] m_inc;
  logic [31:0] m_tstg, m_istg, m_snap;
  logic        m_en, m_rdv;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  string       pend_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_inc = '0; m_tstg = '0; m_istg = '0;
      m_snap = '0; m_en = 1'b0; m_rdv = 1'b0;
    end else begin
      m_rdv = rd_en;
      if (rd_en) begin
        case (addr)
          3'd0: exp_q.push_back({31'd0, m_en});
          3'd1: exp_q.push_back(m_inc[31:0]);
          3'd2: exp_q.push_back(m_inc[63:32]);
          3'd3: begin exp_q.push_back(m_acc[63:32]); m_snap = m_acc[95:64]; end
          3'd4: exp_q.push_back(m_snap);
          default: exp_q.push_back(32'd0);
        endcase
        tag_q.push_back(pend_q.pop_front());
      end
      if (wr_en && addr == 3'd4) m_acc = {wdata, m_tstg, 32'd0};
      else if (m_en)             m_acc = m_acc + {32'd0, m_inc};
      if (wr_en) begin
        case (addr)
          3'd0: m_en = wdata[0];
          3'd1: m_istg = wdata;
          3'd2: m_inc = {wdata, m_istg};
          3'd3: m_tstg = wdata;
          default: ;
        endcase
      end
    end
  end

  // monitor: compare results away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid !== m_rdv) begin
        errors++;
        $display("FAIL R10 rd_valid actual=%0b expected=%0b", rd_valid, m_rdv);
      end
      if (rd_valid && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a; pend_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<50000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R1: all registers zero after reset
    for (int a = 0; a < 5; a++) bus_rd(3'(a), "R1");
    // R11, R8: enable with zero increment
    bus_wr(3'd0, 32'h1);
    bus_rd(3'd0, "R11");
    idle(5);
    bus_rd(3'd3, "R8");
    // R7: low increment word is staged only
    bus_wr(3'd1, 32'h9999_9999);
    bus_rd(3'd1, "R7");
    idle(4);
    bus_rd(3'd3, "R7");
    bus_wr(3'd2, 32'h1);
    bus_rd(3'd1, "R11");
    bus_rd(3'd2, "R11");
    // R3: 1.6 ns per tick with fraction carries
    idle(10);
    bus_rd(3'd3, "R3");
    bus_rd(3'd4, "R3");
    // R2: disabled holds
    bus_wr(3'd0, 32'h0);
    bus_rd(3'd3, "R2");
    idle(8);
    bus_rd(3'd3, "R2");
    // R5: low time write alone does nothing
    bus_wr(3'd3, 32'hFFFF_FFF0);
    bus_rd(3'd3, "R5");
    // R6: high write loads, and clears fraction
    bus_wr(3'd4, 32'hFFFF_FFFF);
    bus_rd(3'd3, "R6");
    bus_rd(3'd4, "R6");
    // R9: wrap with 1 ns per tick
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd2, 32'h1);
    bus_wr(3'd0, 32'h1);
    idle(20);
    bus_rd(3'd3, "R9");
    bus_rd(3'd4, "R9");
    // R6: load while running beats the tick
    bus_wr(3'd3, 32'hFFFF_FFF8);
    bus_wr(3'd4, 32'h0000_0007);
    bus_rd(3'd3, "R6");
    // R4: snapshot of high word across a 32-bit carry
    bus_wr(3'd4, 32'h0000_0000);
    bus_rd(3'd3, "R4");
    idle(20);
    bus_rd(3'd4, "R4");
    bus_rd(3'd3, "R4");
    bus_rd(3'd4, "R4");
    // R3: 32 ns tick (base times 20)
    bus_wr(3'd1, 32'hFFFF_FFF4);
    bus_wr(3'd2, 32'h0000_001F);
    idle(7);
    bus_rd(3'd3, "R3");
    bus_rd(3'd2, "R11");
    // R8: zero increment freezes while enabled
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd2, 32'h0);
    bus_rd(3'd3, "R8");
    idle(6);
    bus_rd(3'd3, "R8");
    idle(3);
    finish_run();
  end
endmodule